// File: doc/BRIEF.md
# Time-Ordered Event Queue with Particle Invalidation

This block is the on-chip pending-event store of a pipelined discrete-event simulator. Every stored event has a timestamp and the tags of the two particles it involves. The block keeps these events sorted by timestamp and always presents the earliest one at its head output. A consumer takes the head through a valid/ready handshake, at a rate of one event per clock.

In the same cycle the queue takes up to four newly predicted events. It also takes one event on a refill port, which returns events from a larger backing store. New events can land anywhere in the order, including in front of the current head.

When a particle changes state, any event that still names it is stale. The queue takes up to four particle tags per cycle and deletes every stored event that names one of those tags. It then closes the gaps this leaves. If the queue cannot hold everything in a cycle, the events that sort last are sent out on overflow lanes toward the backing store.

Top module: `event_order_queue`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `head_valid` is 0 and every `ovf_valid` bit is 0.
- R2: The queue holds its events in nondecreasing timestamp order. When the queue is not empty, the head outputs show the event with the smallest timestamp, one cycle after the cycle in which that event entered.
- R3: When `head_valid` and `head_ready` are both high at a rising edge, the head event is removed at that edge. At most one event is removed this way per cycle. An invalidation in the same cycle does not stop this removal.
- R4: At each edge, every valid lane among `ins_valid[3:0]` and `refill_valid` places its event into the sorted order. This includes a position ahead of the present head. The event is visible from the next cycle on.
- R5: Equal timestamps are resolved by age. Events already stored sort ahead of events arriving in the same cycle. Among arriving events, the refill lane goes first, then insert lanes 0 to 3 in rising index order.
- R6: Each valid `inv_valid[k]` deletes at that edge every stored event whose tag A or tag B equals `inv_tag[k]`, at any position. The remaining events close up in order. Events that arrive in the same cycle are not deleted.
- R7: If the events still held after the pop and invalidation, plus the arrivals, number more than DEPTH (32), only the DEPTH earliest are kept (using the R5 order). In the next cycle, the excess events appear in order on overflow lanes 0, 1, and so on. Lane o carries the event of order position DEPTH+o, and `ovf_valid` is set on exactly those lanes. The excess can include events that were stored earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| head_ready | input | 1 | Consumer takes the head event |
| head_valid | output | 1 | Head event present |
| head_ts | output | 32 | Head timestamp |
| head_tag_a | output | 16 | Head first particle tag |
| head_tag_b | output | 16 | Head second particle tag |
| ins_valid | input | 4 | Per-lane insert strobe |
| ins_ts | input | 4x32 | Insert timestamps |
| ins_tag_a | input | 4x16 | Insert first tags |
| ins_tag_b | input | 4x16 | Insert second tags |
| refill_valid | input | 1 | Refill event strobe |
| refill_ts | input | 32 | Refill timestamp |
| refill_tag_a | input | 16 | Refill first tag |
| refill_tag_b | input | 16 | Refill second tag |
| inv_valid | input | 4 | Per-lane invalidation strobe |
| inv_tag | input | 4x16 | Particle tags to invalidate |
| ovf_valid | output | 5 | Overflow lane strobes, lane 0 earliest |
| ovf_ts | output | 5x32 | Overflow timestamps |
| ovf_tag_a | output | 5x16 | Overflow first tags |
| ovf_tag_b | output | 5x16 | Overflow second tags |

## Verification
The removal-count property only applies in cycles with no arrivals and no invalidation. The stale-tag property only looks at cycles in which no event arrived, because an arriving event is allowed to carry a tag that is being invalidated. The stimulus drives every lane on the falling edge and leaves the fields of unasserted lanes at zero. It draws particle tags from a small range, so that invalidations often hit stored events, and draws timestamps from a narrow range, so that ties occur often. It stalls the consumer long enough to fill the queue and overrun it.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int TS_W  = 32;
    localparam int TAG_W = 16;

    typedef struct packed {
        logic             vld;
        logic [TS_W-1:0]  ts;
        logic [TAG_W-1:0] ta;
        logic [TAG_W-1:0] tb;
    } evq_ent_t;

    // true when the event involves the given particle
    function automatic logic evq_names(evq_ent_t e, logic [TAG_W-1:0] tag);
        return (e.ta == tag) || (e.tb == tag);
    endfunction

endpackage

// File: rtl/evq_survive.sv
// Decides which stored entries survive this cycle and their compacted index.
module evq_survive import evq_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int N_INV = 4,
    parameter int RW    = 6
) (
    input  evq_ent_t [DEPTH-1:0]              q,
    input  logic                              pop,
    input  logic [N_INV-1:0]                  inv_v,
    input  logic [N_INV-1:0][TAG_W-1:0]       inv_tag,
    output logic [DEPTH-1:0]                  keep,
    output logic [DEPTH-1:0][RW-1:0]          pos
);

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            logic [N_INV-1:0] hit;
            always_comb begin
                for (int k = 0; k < N_INV; k++)
                    hit[k] = inv_v[k] && evq_names(q[gi], inv_tag[k]);
            end
            assign keep[gi] = q[gi].vld && !(pop && (gi == 0)) && !(|hit);
        end
    endgenerate

    logic [RW-1:0] acc;
    always_comb begin
        acc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pos[i] = acc;
            acc    = acc + RW'(keep[i]);
        end
    end

endmodule

// File: rtl/evq_merge.sv
// Ranks survivors and arrivals jointly and scatters them into slots or overflow.
module evq_merge import evq_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int NL    = 5,
    parameter int RW    = 6
) (
    input  evq_ent_t [DEPTH-1:0]     q,
    input  logic [DEPTH-1:0]         keep,
    input  logic [DEPTH-1:0][RW-1:0] pos,
    input  evq_ent_t [NL-1:0]        ln,
    output evq_ent_t [DEPTH-1:0]     nq,
    output evq_ent_t [NL-1:0]        ovf
);

    logic [DEPTH-1:0][RW-1:0] srank;
    logic [NL-1:0][RW-1:0]    lrank;

    genvar gi, gj;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_srank
            logic [RW-1:0] r;
            always_comb begin
                r = pos[gi];
                for (int k = 0; k < NL; k++)
                    if (ln[k].vld && (ln[k].ts < q[gi].ts)) r = r + RW'(1);
                srank[gi] = r;
            end
        end
        for (gj = 0; gj < NL; gj++) begin : g_lrank
            logic [RW-1:0] r;
            always_comb begin
                r = '0;
                for (int i = 0; i < DEPTH; i++)
                    if (keep[i] && (q[i].ts <= ln[gj].ts)) r = r + RW'(1);
                for (int k = 0; k < NL; k++)
                    if (ln[k].vld && ((ln[k].ts < ln[gj].ts) ||
                                      ((ln[k].ts == ln[gj].ts) && (k < gj))))
                        r = r + RW'(1);
                lrank[gj] = r;
            end
        end
    endgenerate

    always_comb begin
        nq  = '0;
        ovf = '0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int s = 0; s < DEPTH; s++)
                if (keep[i] && srank[i] == RW'(s)) nq[s] = q[i];
            for (int o = 0; o < NL; o++)
                if (keep[i] && srank[i] == RW'(DEPTH + o)) ovf[o] = q[i];
        end
        for (int j = 0; j < NL; j++) begin
            for (int s = 0; s < DEPTH; s++)
                if (ln[j].vld && lrank[j] == RW'(s)) nq[s] = ln[j];
            for (int o = 0; o < NL; o++)
                if (ln[j].vld && lrank[j] == RW'(DEPTH + o)) ovf[o] = ln[j];
        end
    end

endmodule

// File: rtl/event_order_queue.sv
module event_order_queue import evq_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int N_INS = 4,
    parameter int N_INV = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          head_ready,
    output logic                          head_valid,
    output logic [TS_W-1:0]               head_ts,
    output logic [TAG_W-1:0]              head_tag_a,
    output logic [TAG_W-1:0]              head_tag_b,
    input  logic [N_INS-1:0]              ins_valid,
    input  logic [N_INS-1:0][TS_W-1:0]    ins_ts,
    input  logic [N_INS-1:0][TAG_W-1:0]   ins_tag_a,
    input  logic [N_INS-1:0][TAG_W-1:0]   ins_tag_b,
    input  logic                          refill_valid,
    input  logic [TS_W-1:0]               refill_ts,
    input  logic [TAG_W-1:0]              refill_tag_a,
    input  logic [TAG_W-1:0]              refill_tag_b,
    input  logic [N_INV-1:0]              inv_valid,
    input  logic [N_INV-1:0][TAG_W-1:0]   inv_tag,
    output logic [N_INS:0]                ovf_valid,
    output logic [N_INS:0][TS_W-1:0]      ovf_ts,
    output logic [N_INS:0][TAG_W-1:0]     ovf_tag_a,
    output logic [N_INS:0][TAG_W-1:0]     ovf_tag_b
);

    localparam int NL = N_INS + 1;
    localparam int RW = $clog2(DEPTH + NL + 1);

    evq_ent_t [DEPTH-1:0]     q_r, q_nx;
    evq_ent_t [NL-1:0]        ovf_r, ovf_nx;
    evq_ent_t [NL-1:0]        lanes;
    logic [DEPTH-1:0]         keep;
    logic [DEPTH-1:0][RW-1:0] pos;
    logic                     pop;

    assign pop = q_r[0].vld && head_ready;

    // lane 0 is the refill port: it counts as older than fresh predictions
    always_comb begin
        lanes[0] = '{vld: refill_valid, ts: refill_ts, ta: refill_tag_a, tb: refill_tag_b};
        for (int k = 0; k < N_INS; k++)
            lanes[k+1] = '{vld: ins_valid[k], ts: ins_ts[k], ta: ins_tag_a[k], tb: ins_tag_b[k]};
    end

    evq_survive #(.DEPTH(DEPTH), .N_INV(N_INV), .RW(RW)) u_survive (
        .q(q_r), .pop(pop), .inv_v(inv_valid), .inv_tag(inv_tag),
        .keep(keep), .pos(pos)
    );

    evq_merge #(.DEPTH(DEPTH), .NL(NL), .RW(RW)) u_merge (
        .q(q_r), .keep(keep), .pos(pos), .ln(lanes),
        .nq(q_nx), .ovf(ovf_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            ovf_r <= '0;
        end else begin
            q_r   <= q_nx;
            ovf_r <= ovf_nx;
        end
    end

    assign head_valid = q_r[0].vld;
    assign head_ts    = q_r[0].ts;
    assign head_tag_a = q_r[0].ta;
    assign head_tag_b = q_r[0].tb;

    always_comb begin
        for (int o = 0; o < NL; o++) begin
            ovf_valid[o] = ovf_r[o].vld;
            ovf_ts[o]    = ovf_r[o].ts;
            ovf_tag_a[o] = ovf_r[o].ta;
            ovf_tag_b[o] = ovf_r[o].tb;
        end
    end

endmodule

// File: rtl/event_order_queue_chk.sv
module event_order_queue_chk import evq_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int N_INS = 4,
    parameter int N_INV = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         head_valid,
    input logic                         head_ready,
    input logic [N_INS-1:0]             ins_valid,
    input logic                         refill_valid,
    input logic [N_INV-1:0]             inv_valid,
    input logic [N_INV-1:0][TAG_W-1:0]  inv_tag,
    input logic [N_INS:0]               ovf_valid,
    input evq_ent_t [DEPTH-1:0]         q
);

    logic [DEPTH-1:0] vvec;
    always_comb for (int i = 0; i < DEPTH; i++) vvec[i] = q[i].vld;

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!head_valid && ovf_valid == '0));

    genvar gi;
    generate
        for (gi = 0; gi + 1 < DEPTH; gi++) begin : g_ord
            assert_sorted_R2: assert property (@(posedge clk) disable iff (rst)
                q[gi+1].vld |-> (q[gi].vld && q[gi].ts <= q[gi+1].ts));
        end
    endgenerate

    assert_single_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (head_valid && head_ready && ins_valid == '0 && !refill_valid && inv_valid == '0)
        |=> ($countones(vvec) == $countones($past(vvec)) - 1));

    // registered copy of last cycle's invalidation, valid when nothing arrived
    logic                        last_clean;
    logic [N_INV-1:0]            last_v;
    logic [N_INV-1:0][TAG_W-1:0] last_tag;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_clean <= 1'b0;
            last_v     <= '0;
            last_tag   <= '0;
        end else begin
            last_clean <= (ins_valid == '0) && !refill_valid;
            last_v     <= inv_valid;
            last_tag   <= inv_tag;
        end
    end

    logic stale;
    always_comb begin
        stale = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int k = 0; k < N_INV; k++)
                if (q[i].vld && last_v[k] && evq_names(q[i], last_tag[k])) stale = 1'b1;
    end

    assert_no_stale_R6: assert property (@(posedge clk) disable iff (rst)
        last_clean |-> !stale);

    assert_ovf_full_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_valid != '0) |-> (vvec == '1));

    generate
        for (gi = 0; gi < N_INS; gi++) begin : g_ovf
            assert_ovf_packed_R7: assert property (@(posedge clk) disable iff (rst)
                ovf_valid[gi+1] |-> ovf_valid[gi]);
        end
    endgenerate

endmodule

bind event_order_queue event_order_queue_chk #(.DEPTH(DEPTH), .N_INS(N_INS), .N_INV(N_INV)) u_chk (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_ready(head_ready),
    .ins_valid(ins_valid), .refill_valid(refill_valid), .inv_valid(inv_valid),
    .inv_tag(inv_tag), .ovf_valid(ovf_valid), .q(q_r)
);

// File: tb/event_order_queue_bench.sv
module event_order_queue_bench;

    localparam int DEPTH = 32;
    localparam int NI    = 4;
    localparam int NV    = 4;
    localparam int NL    = NI + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                  head_ready = 1'b0;
    logic                  head_valid;
    logic [31:0]           head_ts;
    logic [15:0]           head_tag_a, head_tag_b;
    logic [NI-1:0]         ins_valid = '0;
    logic [NI-1:0][31:0]   ins_ts = '0;
    logic [NI-1:0][15:0]   ins_tag_a = '0, ins_tag_b = '0;
    logic                  refill_valid = 1'b0;
    logic [31:0]           refill_ts = '0;
    logic [15:0]           refill_tag_a = '0, refill_tag_b = '0;
    logic [NV-1:0]         inv_valid = '0;
    logic [NV-1:0][15:0]   inv_tag = '0;
    logic [NI:0]           ovf_valid;
    logic [NI:0][31:0]     ovf_ts;
    logic [NI:0][15:0]     ovf_tag_a, ovf_tag_b;

    event_order_queue #(.DEPTH(DEPTH), .N_INS(NI), .N_INV(NV)) u_event_order_queue (
        .clk(clk), .rst(rst), .head_ready(head_ready), .head_valid(head_valid),
        .head_ts(head_ts), .head_tag_a(head_tag_a), .head_tag_b(head_tag_b),
        .ins_valid(ins_valid), .ins_ts(ins_ts), .ins_tag_a(ins_tag_a), .ins_tag_b(ins_tag_b),
        .refill_valid(refill_valid), .refill_ts(refill_ts),
        .refill_tag_a(refill_tag_a), .refill_tag_b(refill_tag_b),
        .inv_valid(inv_valid), .inv_tag(inv_tag),
        .ovf_valid(ovf_valid), .ovf_ts(ovf_ts), .ovf_tag_a(ovf_tag_a), .ovf_tag_b(ovf_tag_b)
    );

    typedef struct {
        int unsigned ts;
        int unsigned ta;
        int unsigned tb;
    } mev_t;

    mev_t  mq[$];
    mev_t  mo[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R2";

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic void ins_one(mev_t e);
        int p = mq.size();
        for (int i = 0; i < mq.size(); i++)
            if (mq[i].ts > e.ts) begin p = i; break; end
        mq.insert(p, e);
    endfunction

    // behavioural next state from the requirements
    function automatic void model_step();
        mo.delete();
        if (mq.size() > 0 && head_ready) void'(mq.pop_front());
        for (int i = mq.size() - 1; i >= 0; i--) begin
            bit kill = 0;
            for (int k = 0; k < NV; k++)
                if (inv_valid[k] && (mq[i].ta == inv_tag[k] || mq[i].tb == inv_tag[k])) kill = 1;
            if (kill) mq.delete(i);
        end
        if (refill_valid) ins_one('{refill_ts, refill_tag_a, refill_tag_b});
        for (int k = 0; k < NI; k++)
            if (ins_valid[k]) ins_one('{ins_ts[k], ins_tag_a[k], ins_tag_b[k]});
        while (mq.size() > DEPTH) mo.push_front(mq.pop_back());
    endfunction

    task automatic compare();
        chk(head_valid == (mq.size() > 0), "head_valid", head_valid, mq.size() > 0);
        if (head_valid && mq.size() > 0) begin
            chk(head_ts == mq[0].ts, "head_ts", head_ts, mq[0].ts);
            chk(head_tag_a == mq[0].ta && head_tag_b == mq[0].tb, "head_tags",
                {head_tag_a, head_tag_b}, {mq[0].ta[15:0], mq[0].tb[15:0]});
        end
        for (int o = 0; o < NL; o++) begin
            chk(ovf_valid[o] == (o < mo.size()), "ovf_valid", ovf_valid[o], o < mo.size());
            if (ovf_valid[o] && o < mo.size())
                chk(ovf_ts[o] == mo[o].ts && ovf_tag_a[o] == mo[o].ta && ovf_tag_b[o] == mo[o].tb,
                    "ovf_event_ts", ovf_ts[o], mo[o].ts);
        end
    endtask

    task automatic clear_in();
        ins_valid = '0; ins_ts = '0; ins_tag_a = '0; ins_tag_b = '0;
        refill_valid = 0; refill_ts = '0; refill_tag_a = '0; refill_tag_b = '0;
        inv_valid = '0; inv_tag = '0;
    endtask

    // inputs already set at a falling edge: advance one cycle and compare
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        clear_in();
    endtask

    task automatic put(int lane, int unsigned ts, int unsigned ta, int unsigned tb);
        ins_valid[lane] = 1; ins_ts[lane] = ts; ins_tag_a[lane] = ta[15:0]; ins_tag_b[lane] = tb[15:0];
    endtask

    task automatic drain(int n);
        head_ready = 1;
        repeat (n) step();
        head_ready = 0;
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk(head_valid == 0, "head_valid in reset", head_valid, 0);
        chk(ovf_valid == '0, "ovf_valid in reset", ovf_valid, 0);
        rst = 0;
        @(posedge clk); @(negedge clk);
        chk(head_valid == 0, "head_valid after reset", head_valid, 0);
        chk(ovf_valid == '0, "ovf_valid after reset", ovf_valid, 0);

        // R4: arbitrary-position insertion, then one ahead of the head
        cur_req = "R4";
        put(0, 50, 1, 2); put(1, 20, 3, 4); put(2, 40, 5, 6); put(3, 30, 7, 8);
        step();
        chk(head_ts == 20, "head after first batch", head_ts, 20);
        refill_valid = 1; refill_ts = 10; refill_tag_a = 9; refill_tag_b = 10;
        put(2, 35, 11, 12);
        step();
        chk(head_ts == 10, "insert ahead of head", head_ts, 10);
        drain(7);

        // R5: ties resolved stored first, then refill, then lanes by index
        cur_req = "R5";
        put(3, 100, 40, 41);
        step();
        refill_valid = 1; refill_ts = 100; refill_tag_a = 42; refill_tag_b = 43;
        put(0, 100, 44, 45); put(1, 100, 46, 47); put(2, 99, 48, 49);
        step();
        drain(7);

        // R6: invalidate by either tag; same-cycle arrival with that tag survives
        cur_req = "R6";
        put(0, 10, 1, 2); put(1, 20, 3, 4); put(2, 30, 2, 5); put(3, 40, 6, 7);
        step();
        inv_valid[1] = 1; inv_tag[1] = 2;
        inv_valid[3] = 1; inv_tag[3] = 7;
        put(0, 5, 2, 9);
        step();
        chk(head_ts == 5 && head_tag_a == 2, "arrival survives invalidation", head_ts, 5);
        drain(4);

        // R3: pop every cycle while feeding one event per cycle
        cur_req = "R3";
        put(0, 1000, 20, 21);
        step();
        head_ready = 1;
        inv_valid[0] = 1; inv_tag[0] = 20;
        step();
        chk(head_valid == 0, "popped head with invalidation", head_valid, 0);
        for (int c = 0; c < 20; c++) begin
            put(c % NI, 500 + c * 3, 30 + c, 60 + c);
            step();
        end
        head_ready = 0;
        drain(4);

        // R7: overrun with the consumer stalled
        cur_req = "R7";
        for (int c = 0; c < 9; c++) begin
            refill_valid = 1; refill_ts = 300 - c; refill_tag_a = 100; refill_tag_b = 101;
            for (int k = 0; k < NI; k++) put(k, 200 + (c * 7 + k * 13) % 50, c, k);
            step();
        end
        drain(DEPTH + 2);

        // R2: mixed random traffic with narrow tag and time ranges
        cur_req = "R2";
        for (int c = 0; c < 3000; c++) begin
            head_ready = ($urandom_range(0, 1) == 1);
            for (int k = 0; k < NI; k++)
                if ($urandom_range(0, 3) == 0)
                    put(k, $urandom_range(0, 63), $urandom_range(0, 15), $urandom_range(0, 15));
            if ($urandom_range(0, 5) == 0) begin
                refill_valid = 1; refill_ts = $urandom_range(0, 63);
                refill_tag_a = 16'($urandom_range(0, 15)); refill_tag_b = 16'($urandom_range(0, 15));
            end
            for (int k = 0; k < NV; k++)
                if ($urandom_range(0, 7) == 0) begin
                    inv_valid[k] = 1; inv_tag[k] = 16'($urandom_range(0, 15));
                end
            step();
        end
        drain(DEPTH + 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog expired actual=0 expected=1", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule